// File: doc/BRIEF.md
# Receive Error-Bit Policy for a Consumer-Electronics Control Bus

This block sits between the bit-timing detector of a single-wire consumer-electronics control bus receiver and the line driver. For every timing error the detector reports, it decides whether reception of the current message ends and whether the line driver should put an error bit on the bus. The choice depends on the kind of error (a rising edge at the wrong time, a bit period that is too short, a bit period that is too long), on whether the current message is broadcast, and on five configuration bits. Each error kind also leaves a sticky flag that software clears by writing a one.

The detector pulses one strobe per error and `msg_start` at the start of every message, together with a valid `msg_bcast` for that message. The block answers one clock later with single-cycle pulses on `stop_rx` and `errbit_req`. At most one error bit is requested per message.

Top module: `cecpol_top`

## Requirements
- R1: A rising error pulses `stop_rx` only when `cfg_stop_on_rise` is 1; a short-period or long-period error always pulses `stop_rx`.
- R2: In a directly addressed message (`msg_bcast`=0), a rising error requests an error bit only when `cfg_gen_on_rise` and `cfg_stop_on_rise` are both 1.
- R3: In a directly addressed message, a long-period error requests an error bit exactly when `cfg_gen_on_long` is 1.
- R4: In a directly addressed message, a short-period error always requests an error bit.
- R5: In a broadcast message with `cfg_bcast_quiet`=1, no error of any kind requests an error bit.
- R6: In a broadcast message with `cfg_bcast_quiet`=0, a rising error requests an error bit whenever `cfg_stop_on_rise` is 1 (whatever `cfg_gen_on_rise`), and a long-period error always requests one (whatever `cfg_gen_on_long`).
- R7: In a broadcast message, a short-period error requests an error bit only when both `cfg_bcast_quiet` and `cfg_listen_all` are 0.
- R8: `err_flags` bit 0 records rising errors, bit 1 short-period errors, bit 2 long-period errors; a flag is set the cycle after its strobe, stays set, is cleared by a 1 on the same bit of `flag_clr`, and a new error wins over a clear in the same cycle.
- R9: `stop_rx` and `errbit_req` are registered single-cycle pulses that appear in the cycle after the strobe that caused them.
- R10: At most one error bit is requested between two `msg_start` pulses; `msg_start` re-arms the request for the message it opens (an error strobed in the same cycle belongs to the new message), and the block is armed after reset.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_stop_on_rise | input | 1 | Rising error ends reception |
| cfg_gen_on_rise | input | 1 | Error bit on rising error (direct messages) |
| cfg_gen_on_long | input | 1 | Error bit on long-period error (direct messages) |
| cfg_bcast_quiet | input | 1 | Suppress all error bits in broadcast messages |
| cfg_listen_all | input | 1 | Listen to all traffic; silences short-period error bits in broadcasts |
| msg_start | input | 1 | Pulse at the start of a message |
| msg_bcast | input | 1 | Current message is broadcast |
| err_rise | input | 1 | Rising-error strobe |
| err_short | input | 1 | Short-period error strobe |
| err_long | input | 1 | Long-period error strobe |
| flag_clr | input | 3 | Write-one-to-clear for `err_flags` |
| stop_rx | output | 1 | Stop-reception pulse |
| errbit_req | output | 1 | Error-bit request pulse |
| err_flags | output | 3 | Sticky error flags |

## Verification
The bench sweeps every combination of the five configuration bits, both message kinds and all three error kinds, so a design that let a per-error enable leak into broadcast handling, or that ignored the stop condition when granting a rising-error bit, shows a wrong `errbit_req` in some cell. Separate sequences send a second error inside one message, where a design without the per-message arming would request twice, and strobe an error in the same cycle as `msg_start`, where a design that re-arms one cycle late would stay silent. A clear that coincides with a new error checks that the flag survives, which a clear-first implementation would lose.

// File: rtl/cecpol_pkg.sv
package cecpol_pkg;

  localparam int NUM_ERR = 3;
  localparam int IDX_RISE  = 0;
  localparam int IDX_SHORT = 1;
  localparam int IDX_LONG  = 2;

  typedef struct packed {
    logic stop_on_rise;
    logic gen_on_rise;
    logic gen_on_long;
    logic bcast_quiet;
    logic listen_all;
  } cecpol_cfg_t;

  // Does this error kind end reception?
  function automatic logic f_stop(input int kind, input cecpol_cfg_t c);
    if (kind == IDX_RISE) return c.stop_on_rise;
    return 1'b1;
  endfunction

  // Does this error kind ask for an error bit on the line?
  function automatic logic f_errbit(input int kind, input cecpol_cfg_t c,
                                    input logic bcast);
    logic r;
    r = 1'b0;
    if (bcast) begin
      if (!c.bcast_quiet) begin
        case (kind)
          IDX_RISE:  r = c.stop_on_rise;
          IDX_SHORT: r = !c.listen_all;
          default:   r = 1'b1;
        endcase
      end
    end else begin
      case (kind)
        IDX_RISE:  r = c.stop_on_rise & c.gen_on_rise;
        IDX_SHORT: r = 1'b1;
        default:   r = c.gen_on_long;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/cecpol_decide.sv
module cecpol_decide
  import cecpol_pkg::*;
#(
  parameter int N = NUM_ERR
) (
  input  cecpol_cfg_t  cfg,
  input  logic         bcast,
  input  logic [N-1:0] strobe,
  output logic         stop_any,
  output logic         errbit_any
);
  logic [N-1:0] stop_vec;
  logic [N-1:0] eb_vec;

  for (genvar k = 0; k < N; k++) begin : g_kind
    assign stop_vec[k] = strobe[k] & f_stop(k, cfg);
    assign eb_vec[k]   = strobe[k] & f_errbit(k, cfg, bcast);
  end

  assign stop_any   = |stop_vec;
  assign errbit_any = |eb_vec;
endmodule

// File: rtl/cecpol_flags.sv
module cecpol_flags #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flags_o[k] <= 1'b0;
      else if (set_i[k]) flags_o[k] <= 1'b1;
      else if (clr_i[k]) flags_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/cecpol_pulse.sv
module cecpol_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic new_msg,
  input  logic stop_want,
  input  logic eb_want,
  output logic stop_o,
  output logic eb_o,
  output logic eb_fire
);
  logic armed_q;
  logic armed_eff;

  assign armed_eff = armed_q | new_msg;
  assign eb_fire   = eb_want & armed_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      stop_o  <= 1'b0;
      eb_o    <= 1'b0;
    end else begin
      armed_q <= armed_eff & ~eb_fire;
      stop_o  <= stop_want;
      eb_o    <= eb_fire;
    end
  end
endmodule

// File: rtl/cecpol_top.sv
module cecpol_top
  import cecpol_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_stop_on_rise,
  input  logic               cfg_gen_on_rise,
  input  logic               cfg_gen_on_long,
  input  logic               cfg_bcast_quiet,
  input  logic               cfg_listen_all,
  input  logic               msg_start,
  input  logic               msg_bcast,
  input  logic               err_rise,
  input  logic               err_short,
  input  logic               err_long,
  input  logic [NUM_ERR-1:0] flag_clr,
  output logic               stop_rx,
  output logic               errbit_req,
  output logic [NUM_ERR-1:0] err_flags
);
  cecpol_cfg_t        cfg;
  logic [NUM_ERR-1:0] strobe;
  logic               stop_want;
  logic               eb_want;
  logic               eb_fire;

  assign cfg = '{stop_on_rise: cfg_stop_on_rise, gen_on_rise: cfg_gen_on_rise,
                 gen_on_long: cfg_gen_on_long, bcast_quiet: cfg_bcast_quiet,
                 listen_all: cfg_listen_all};

  assign strobe[IDX_RISE]  = err_rise;
  assign strobe[IDX_SHORT] = err_short;
  assign strobe[IDX_LONG]  = err_long;

  cecpol_decide #(.N(NUM_ERR)) u_decide (
    .cfg        (cfg),
    .bcast      (msg_bcast),
    .strobe     (strobe),
    .stop_any   (stop_want),
    .errbit_any (eb_want)
  );

  cecpol_pulse u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_msg   (msg_start),
    .stop_want (stop_want),
    .eb_want   (eb_want),
    .stop_o    (stop_rx),
    .eb_o      (errbit_req),
    .eb_fire   (eb_fire)
  );

  cecpol_flags #(.W(NUM_ERR)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (strobe),
    .clr_i   (flag_clr),
    .flags_o (err_flags)
  );
endmodule

// File: rtl/cecpol_checker.sv
module cecpol_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_stop_on_rise,
  input logic       cfg_bcast_quiet,
  input logic       msg_start,
  input logic       msg_bcast,
  input logic       err_rise,
  input logic       err_short,
  input logic       err_long,
  input logic [2:0] flag_clr,
  input logic       stop_rx,
  input logic       errbit_req,
  input logic [2:0] err_flags
);
  logic prev_start;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_start <= 1'b1;
      seen_q     <= 1'b0;
    end else begin
      prev_start <= msg_start;
      seen_q     <= prev_start ? errbit_req : (seen_q | errbit_req);
    end
  end

  assert_rise_nostop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rise && !err_short && !err_long && !cfg_stop_on_rise) |=> !stop_rx);

  assert_bcast_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_rise || err_short || err_long) && msg_bcast && cfg_bcast_quiet) |=> !errbit_req);

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_rise |=> err_flags[0]);

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[2] && !flag_clr[2]) |=> err_flags[2]);

  assert_req_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    errbit_req |-> $past(err_rise || err_short || err_long));

  assert_one_per_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    errbit_req |-> (prev_start || !seen_q));
endmodule

bind cecpol_top cecpol_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_stop_on_rise (cfg_stop_on_rise),
  .cfg_bcast_quiet  (cfg_bcast_quiet),
  .msg_start        (msg_start),
  .msg_bcast        (msg_bcast),
  .err_rise         (err_rise),
  .err_short        (err_short),
  .err_long         (err_long),
  .flag_clr         (flag_clr),
  .stop_rx          (stop_rx),
  .errbit_req       (errbit_req),
  .err_flags        (err_flags)
);

// File: tb/tb_cecpol_top.sv
module tb_cecpol_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_sr = 0, c_gr = 0, c_gl = 0, c_bq = 0, c_la = 0;
  logic ms = 0, bc = 0, er = 0, es = 0, el = 0;
  logic [2:0] clr = '0;
  logic stop_rx, errbit_req;
  logic [2:0] err_flags;
  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  cecpol_top dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_stop_on_rise(c_sr), .cfg_gen_on_rise(c_gr), .cfg_gen_on_long(c_gl),
    .cfg_bcast_quiet(c_bq), .cfg_listen_all(c_la),
    .msg_start(ms), .msg_bcast(bc),
    .err_rise(er), .err_short(es), .err_long(el),
    .flag_clr(clr),
    .stop_rx(stop_rx), .errbit_req(errbit_req), .err_flags(err_flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cfg=%b%b%b%b%b bc=%0b)",
               req, act, exp, c_sr, c_gr, c_gl, c_bq, c_la, bc);
    end
  endtask

  // Model: kind 0 rise, 1 short, 2 long
  function automatic int m_stop(input int kind);
    return (kind == 0) ? int'(c_sr) : 1;
  endfunction

  function automatic int m_req(input int kind);
    int direct_tbl;
    int bc_tbl;
    direct_tbl = (kind == 0) ? int'(c_gr) * int'(c_sr) : (kind == 1) ? 1 : int'(c_gl);
    bc_tbl     = (1 - int'(c_bq)) *
                 ((kind == 0) ? int'(c_sr) : (kind == 1) ? (1 - int'(c_la)) : 1);
    return bc ? bc_tbl : direct_tbl;
  endfunction

  function automatic string tag(input int kind);
    if (bc && c_bq) return "R5";
    if (bc) return (kind == 1) ? "R7" : "R6";
    return (kind == 0) ? "R2" : (kind == 1) ? "R4" : "R3";
  endfunction

  task automatic strobe(input int kind);
    er = (kind == 0); es = (kind == 1); el = (kind == 2);
    @(negedge clk);
    er = 0; es = 0; el = 0;
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 stop_rx", int'(stop_rx), 0);
    chk("R11 errbit_req", int'(errbit_req), 0);
    chk("R11 err_flags", int'(err_flags), 0);
    rst_n = 1;
    @(negedge clk);

    // Exhaustive sweep over configuration, message kind, error kind
    for (int cv = 0; cv < 32; cv++) begin
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 3; k++) begin
          {c_sr, c_gr, c_gl, c_bq, c_la} = 5'(cv);
          bc = b[0];
          ms = 1;
          @(negedge clk);
          ms = 0;
          strobe(k);
          chk("R1 stop_rx", int'(stop_rx), m_stop(k));
          chk(tag(k), int'(errbit_req), m_req(k));
          chk("R8 flag set", int'(err_flags[k]), 1);
          @(negedge clk);
          chk("R9 stop pulse width", int'(stop_rx), 0);
          chk("R9 req pulse width", int'(errbit_req), 0);
          clr = 3'b111;
          @(negedge clk);
          clr = 3'b000;
          chk("R8 flag cleared", int'(err_flags), 0);
        end
      end
    end

    // R10: second error in same message does not request again
    {c_sr, c_gr, c_gl, c_bq, c_la} = 5'b00000;
    bc = 0;
    ms = 1; @(negedge clk); ms = 0;
    strobe(1);
    chk("R10 first req", int'(errbit_req), 1);
    @(negedge clk);
    strobe(1);
    chk("R10 second req suppressed", int'(errbit_req), 0);
    chk("R1 stop still pulses", int'(stop_rx), 1);
    // R10: error in same cycle as msg_start belongs to new message
    ms = 1; es = 1;
    @(negedge clk);
    ms = 0; es = 0;
    chk("R10 rearm same cycle", int'(errbit_req), 1);
    @(negedge clk);
    strobe(2);
    c_gl = 0;
    chk("R10 after rearm consumed", int'(errbit_req), 0);

    // R8: set wins over clear in the same cycle; other bits unaffected
    clr = 3'b111; @(negedge clk); clr = 3'b000;
    er = 1; clr = 3'b001;
    @(negedge clk);
    er = 0; clr = 3'b000;
    chk("R8 set beats clear", int'(err_flags[0]), 1);
    el = 1; @(negedge clk); el = 0;
    clr = 3'b100; @(negedge clk); clr = 3'b000;
    chk("R8 clear only selected bit", int'(err_flags), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule